// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition Flags

This block performs the arithmetic and logical step of a small teaching processor. It receives two register operands, `val_a` (first source) and `val_b` (second source, which is also the destination), plus a 4-bit operation selector. It returns the operation result combinationally, in the same cycle. Surrounding logic writes that result back into the destination register.

Three condition flags sit next to the datapath: overflow, zero and sign. They are held in a register with a synchronous active-low reset. The flags load on a rising clock edge only when the flag-load strobe is high and the selector names a defined operation. Branch-condition logic reads the registered flags directly.

A selector outside the defined set has three effects. The result is forced to zero, an error output is raised, and the flags are left unchanged.

Top module: `alu_cc_top`

## Requirements
- R1: Selector value 0 gives result = val_b + val_a, modulo 2^WIDTH.
- R2: Selector value 1 gives result = val_b - val_a, modulo 2^WIDTH (the first operand is taken from the second).
- R3: Selector value 2 gives val_b AND val_a, and selector value 3 gives val_b XOR val_a.
- R4: On a rising edge with rst_n high, set_cc high and a defined selector (0 to 3), the flags load as follows:
  - cc_zf is set to 1 exactly when the result is all zeros.
  - cc_sf is set to result bit WIDTH-1.
- R5: For selector 0, the loaded cc_of is 1 exactly when val_a and val_b have equal sign bits and the result sign bit differs from them.
- R6: For selector 1, the loaded cc_of is 1 exactly when the sign bits of val_b and val_a differ and the result sign bit differs from that of val_b.
- R7: For selectors 2 and 3, the loaded cc_of is 0.
- R8: A rising edge with rst_n low sets cc_zf=1, cc_sf=0 and cc_of=0.
- R9: A rising edge with set_cc low leaves all three flags unchanged.
- R10: For selector values 4 to 15, all of the following hold:
  - result is 0.
  - fn_err is 1.
  - The flags keep their values even when set_cc is high.
  - For selectors 0 to 3, fn_err is 0.
- R11: result and fn_err follow the inputs combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| fn_code | input | 4 | Operation selector |
| val_a | input | WIDTH | First source operand |
| val_b | input | WIDTH | Second source operand, also the destination |
| set_cc | input | 1 | Flag-load strobe |
| result | output | WIDTH | Operation result |
| fn_err | output | 1 | High for an undefined selector |
| cc_of | output | 1 | Registered overflow flag |
| cc_zf | output | 1 | Registered zero flag |
| cc_sf | output | 1 | Registered sign flag |

## Verification
The bench builds the block with the default WIDTH of 32. At that width the operands reach the exact sign boundaries where overflow first appears, such as 0x7FFFFFFF plus 1 and 0x80000000 minus 1. It also covers results that wrap to exactly zero, and a subtraction of a negative operand from a non-negative one. The undefined-selector cases are checked with set_cc held high, so that a flag load which should be blocked would show up in the flags.

// File: rtl/alu_cc_pkg.sv
// Package: shared types for the ALU and its condition flags.
// Assumes: the selector is 4 bits wide; only codes 0..3 are defined.
package alu_cc_pkg;

    localparam int FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_XOR = 4'd3
    } alu_fn_e;

    typedef struct packed {
        logic of;
        logic zf;
        logic sf;
    } cc_flags_t;

    localparam cc_flags_t CC_RESET = '{of: 1'b0, zf: 1'b1, sf: 1'b0};

endpackage

// File: rtl/alu_op_unit.sv
// Module: alu_op_unit
// Computes the combinational result and the per-operation overflow bit.
// Assumes: val_b is the destination operand; subtraction is val_b - val_a.
module alu_op_unit
    import alu_cc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [FN_W-1:0]  fn_code,
    input  logic [WIDTH-1:0] val_a,
    input  logic [WIDTH-1:0] val_b,
    output logic [WIDTH-1:0] result,
    output logic             ovf,
    output logic             fn_valid
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] dif_w;

    // Adder and subtractor share nothing; both evaluated in parallel.
    always_comb begin
        sum_w = val_b + val_a;
        dif_w = val_b - val_a;
    end

    // Select result and overflow according to the operation.
    always_comb begin
        result   = '0;
        ovf      = 1'b0;
        fn_valid = 1'b1;
        unique case (fn_code)
            FN_ADD: begin
                result = sum_w;
                ovf    = (val_a[MSB] == val_b[MSB]) && (sum_w[MSB] != val_b[MSB]);
            end
            FN_SUB: begin
                result = dif_w;
                ovf    = (val_a[MSB] != val_b[MSB]) && (dif_w[MSB] != val_b[MSB]);
            end
            FN_AND: result = val_b & val_a;
            FN_XOR: result = val_b ^ val_a;
            default: fn_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_flag_calc.sv
// Module: alu_flag_calc
// Forms candidate flag values from a result and its overflow bit.
// Assumes: ovf is already zero for logical operations.
module alu_flag_calc
    import alu_cc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] result,
    input  logic             ovf,
    output cc_flags_t        flags_nxt
);
    // Zero detect and sign pick.
    always_comb begin
        flags_nxt.of = ovf;
        flags_nxt.zf = (result == '0);
        flags_nxt.sf = result[WIDTH-1];
    end
endmodule

// File: rtl/alu_cc_reg.sv
// Module: alu_cc_reg
// Holds the three condition flags; synchronous active-low reset.
// Assumes: load is already qualified by operation validity.
module alu_cc_reg
    import alu_cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  cc_flags_t flags_nxt,
    output cc_flags_t flags_q
);
    // Flag register update.
    always_ff @(posedge clk) begin
        if (!rst_n)    flags_q <= CC_RESET;
        else if (load) flags_q <= flags_nxt;
    end

    // R8: reset value after a reset edge.
    a_r8_reset_value: assert property (@(posedge clk)
        !rst_n |=> (flags_q == CC_RESET));

    // R9: no load keeps the flags.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flags_q));
endmodule

// File: rtl/alu_cc_top.sv
// Module: alu_cc_top
// ALU plus condition-flag register; result combinational, flags registered.
// Assumes: fn_code 4..15 is undefined and must not disturb the flags.
module alu_cc_top
    import alu_cc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       fn_code,
    input  logic [WIDTH-1:0] val_a,
    input  logic [WIDTH-1:0] val_b,
    input  logic             set_cc,
    output logic [WIDTH-1:0] result,
    output logic             fn_err,
    output logic             cc_of,
    output logic             cc_zf,
    output logic             cc_sf
);
    localparam int MSB = WIDTH - 1;

    logic      ovf;
    logic      fn_valid;
    cc_flags_t flags_nxt;
    cc_flags_t flags_q;
    logic      load;

    alu_op_unit #(.WIDTH(WIDTH)) u_op (
        .fn_code (fn_code),
        .val_a   (val_a),
        .val_b   (val_b),
        .result  (result),
        .ovf     (ovf),
        .fn_valid(fn_valid)
    );

    alu_flag_calc #(.WIDTH(WIDTH)) u_flag (
        .result   (result),
        .ovf      (ovf),
        .flags_nxt(flags_nxt)
    );

    // Qualify the strobe with a defined operation.
    always_comb begin
        load   = set_cc & fn_valid;
        fn_err = ~fn_valid;
    end

    alu_cc_reg u_cc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .flags_nxt(flags_nxt),
        .flags_q  (flags_q)
    );

    // Drive flag outputs.
    always_comb begin
        cc_of = flags_q.of;
        cc_zf = flags_q.zf;
        cc_sf = flags_q.sf;
    end

    // R10: undefined selector yields zero result.
    a_r10_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code > 4'd3) |-> (result == '0 && fn_err));

    // R10: undefined selector leaves flags alone.
    a_r10_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code > 4'd3) |=> ($stable(cc_of) && $stable(cc_zf) && $stable(cc_sf)));

    // R7: logical ops clear overflow.
    a_r7_logic_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && (fn_code == 4'd2 || fn_code == 4'd3)) |=> !cc_of);

    // R4: zero and sign track the loaded result.
    a_r4_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && fn_code <= 4'd3) |=>
        (cc_zf == ($past(result) == '0) && cc_sf == $past(result[MSB])));

    // R5: add overflow rule.
    a_r5_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && fn_code == 4'd0) |=>
        (cc_of == (($past(val_a[MSB]) == $past(val_b[MSB])) &&
                   ($past(result[MSB]) != $past(val_b[MSB])))));
endmodule

// File: tb/tb_alu_cc_top.sv
// Bench: scoreboard for alu_cc_top. The driver checks combinational outputs
// and queues the expected flags; the monitor pops them after each edge.
module tb_alu_cc_top;
    localparam int  W      = 32;
    localparam time PERIOD = 10;

    typedef struct {
        logic  of;
        logic  zf;
        logic  sf;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   fn_code = '0;
    logic [W-1:0] val_a = '0;
    logic [W-1:0] val_b = '0;
    logic         set_cc = 1'b0;
    logic [W-1:0] result;
    logic         fn_err, cc_of, cc_zf, cc_sf;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb_q[$];

    // Reference flag state.
    logic m_of = 1'b0, m_zf = 1'b1, m_sf = 1'b0;

    alu_cc_top #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .fn_code(fn_code), .val_a(val_a),
        .val_b(val_b), .set_cc(set_cc), .result(result), .fn_err(fn_err),
        .cc_of(cc_of), .cc_zf(cc_zf), .cc_sf(cc_sf)
    );

    always #(PERIOD/2) clk = ~clk;

    // Drive one cycle, check combinational outputs, queue expected flags.
    task automatic apply(input logic rst, input logic [3:0] fn,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic set);
        logic [W-1:0] er;
        logic         eo, ev;
        string        rtag, ftag;
        exp_t         it;
        @(negedge clk);
        rst_n = rst; fn_code = fn; val_a = a; val_b = b; set_cc = set;
        ev = 1'b1; eo = 1'b0;
        case (fn)
            4'd0: begin er = b + a; rtag = "R1/R11"; ftag = "R4/R5";
                  eo = (a[W-1] == b[W-1]) && (er[W-1] != b[W-1]); end
            4'd1: begin er = b - a; rtag = "R2/R11"; ftag = "R4/R6";
                  eo = (a[W-1] != b[W-1]) && (er[W-1] != b[W-1]); end
            4'd2: begin er = b & a; rtag = "R3/R11"; ftag = "R4/R7"; end
            4'd3: begin er = b ^ a; rtag = "R3/R11"; ftag = "R4/R7"; end
            default: begin er = '0; ev = 1'b0; rtag = "R10"; ftag = "R10"; end
        endcase
        #(PERIOD/4);
        checks++;
        if (result !== er || fn_err !== !ev) begin
            errors++;
            $display("FAIL %s: result=%h err=%b expected result=%h err=%b",
                     rtag, result, fn_err, er, !ev);
        end
        if (!rst) begin
            {m_of, m_zf, m_sf} = 3'b010; ftag = "R8";
        end else if (!set) begin
            ftag = "R9";
        end else if (ev) begin
            m_of = eo; m_zf = (er == '0); m_sf = er[W-1];
        end
        it.of = m_of; it.zf = m_zf; it.sf = m_sf; it.tag = ftag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare registered flags after every edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if ({cc_of, cc_zf, cc_sf} !== {e.of, e.zf, e.sf}) begin
                    errors++;
                    $display("FAIL %s: flags of/zf/sf=%b%b%b expected %b%b%b",
                             e.tag, cc_of, cc_zf, cc_sf, e.of, e.zf, e.sf);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(PERIOD*5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        apply(1'b0, 4'd0, 32'h0, 32'h0, 1'b0);                    // R8 reset
        apply(1'b0, 4'd0, 32'h1, 32'h1, 1'b1);                    // R8 reset beats set
        apply(1'b1, 4'd0, 32'h7FFFFFFF, 32'h1, 1'b1);             // R5 pos overflow
        apply(1'b1, 4'd0, 32'h80000000, 32'h80000000, 1'b1);      // R5 neg overflow, zero
        apply(1'b1, 4'd0, 32'hFFFFFFFF, 32'h1, 1'b1);             // R1 wrap to zero
        apply(1'b1, 4'd0, 32'h12345678, 32'h11111111, 1'b1);      // R1 plain
        apply(1'b1, 4'd1, 32'h1, 32'h80000000, 1'b1);             // R6 overflow
        apply(1'b1, 4'd1, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1);      // R6 overflow
        apply(1'b1, 4'd1, 32'h5, 32'h3, 1'b1);                    // R2 negative
        apply(1'b1, 4'd1, 32'h42, 32'h42, 1'b1);                  // R2 zero
        apply(1'b1, 4'd0, 32'h7FFFFFFF, 32'h1, 1'b1);             // set OF
        apply(1'b1, 4'd2, 32'hF0F0F0F0, 32'hFF00FF00, 1'b1);      // R7 AND clears OF
        apply(1'b1, 4'd2, 32'h0F0F0F0F, 32'hF0F0F0F0, 1'b1);      // R3 AND zero
        apply(1'b1, 4'd3, 32'hAAAAAAAA, 32'h55555555, 1'b1);      // R3 XOR
        apply(1'b1, 4'd1, 32'h0, 32'h1, 1'b0);                    // R9 hold
        apply(1'b1, 4'd0, 32'h0, 32'h0, 1'b0);                    // R9 hold
        apply(1'b1, 4'd0, 32'h7FFFFFFF, 32'h1, 1'b1);             // OF=1, SF=1
        apply(1'b1, 4'd4, 32'h0, 32'h0, 1'b1);                    // R10
        apply(1'b1, 4'd9, 32'h1, 32'h2, 1'b1);                    // R10
        apply(1'b1, 4'd15, 32'hFFFFFFFF, 32'h0, 1'b1);            // R10
        apply(1'b1, 4'd3, 32'h1234, 32'h1234, 1'b1);              // R3 XOR zero
        apply(1'b1, 4'd0, 32'h0, 32'h0, 1'b0);                    // drain
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule